// File: doc/BRIEF.md
# Bit-Serial 16-Byte Memory Slave

This block behaves like a very small non-volatile memory of sixteen 8-bit cells. A host reaches it through three sampled pin levels: an active-high select that cancels any transfer in progress, a serial clock, and a serial data input. A single registered data-output bit returns read data. All inputs are synchronous samples taken on the system clock, and the block acts only on a low-to-high transition of the sampled serial clock.

A transfer is sixteen serial clock edges long. The first eight edges shift in a command byte, most significant bit first. The upper four bits of that byte give the operation: 0x5 reads and 0xA writes. The lower four bits give the cell index. For any other operation code the block drops back to idle after the eighth edge. For a valid operation, the next eight edges move the cell's bits, most significant first. On a write, each incoming bit replaces one stored bit. On a read, each edge loads the matching stored bit into the output register. There is no acknowledge phase. Once the sixteenth edge is done, the block is ready for the next command at once, with no need to toggle select.

There are two reset inputs. A plain reset returns the sequencer to idle and keeps the stored contents. A power-on clear does the same and also zeroes every cell.

Top module: `nvSerialMem`

## Requirements
- R1: While `rst` is high, the block goes to this state: bit counter at zero, command register at zero, `sdoOut` at 1, and the stored previous serial-clock level at 1. A plain reset leaves the sixteen cells unchanged.
- R2: `powerClr` has every effect of R1. In addition it sets all sixteen cells to 0x00.
- R3: While `selIn` is high, the bit counter is held at zero and no cell changes. A transfer cut short by select therefore keeps only the bits already written, and the next transfer begins a new command.
- R4: A serial bit is taken only in a cycle where `sclkIn` is 1 and its sampled level in the previous cycle was 0. Holding the clock high for extra cycles, or a falling transition, takes no bit.
- R5: The first eight taken bits form the command byte, most significant bit first. Command bits [3:0] select the cell, 0 to 15.
- R6: If command bits [7:4] are neither 0x5 nor 0xA, the block returns to idle after the eighth bit. The next taken bit is then the first bit of a new command.
- R7: With operation 0xA, taken bits 9 to 16 replace bits 7 down to 0 of the selected cell, in that order.
- R8: With operation 0x5, taken bits 9 to 16 load bits 7 down to 0 of the selected cell into `sdoOut`. The load happens on the same system clock edge that takes the bit.
- R9: After the sixteenth taken bit the block is idle. A new command may follow directly, without a select pulse.
- R10: `sdoOut` changes only on a read data bit or on a reset. Writes, commands and aborted commands leave it unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset that keeps the memory contents |
| powerClr | input | 1 | Synchronous active-high power-on clear; also zeroes the memory |
| selIn | input | 1 | Sampled select level; high cancels and holds idle |
| sclkIn | input | 1 | Sampled serial clock level |
| sdiIn | input | 1 | Sampled serial data input |
| sdoOut | output | 1 | Registered serial data output |

## Verification
The hardest state to reach from the ports is a write cut off partway through its data phase. Select has to rise after a chosen number of data edges, and the expected cell is then a mix of old and new bits. The bench writes three data bits of a write to cell 5, raises select, and reads the cell back to check that only the top three bits changed. Two other cases are also exercised. An unknown operation code is followed at once by a new command, with no select pulse, to check that the counter wrapped correctly. Serial clock highs that last several system cycles are used to check that no bit is taken twice.

// File: rtl/nvSerialPkg.sv
package nvSerialPkg;
  localparam int NV_ADDR_W   = 4;
  localparam int NV_DATA_W   = 8;
  localparam int NV_CMD_W    = 8;
  localparam int NV_OP_W     = NV_CMD_W - NV_ADDR_W;
  localparam int NV_DEPTH    = 1 << NV_ADDR_W;
  localparam int NV_BIT_W    = $clog2(NV_DATA_W);
  localparam int NV_FRAME    = NV_CMD_W + NV_DATA_W;
  localparam int NV_CNT_W    = $clog2(NV_FRAME);
  localparam int NV_LAST_CNT = NV_FRAME - 1;

  localparam logic [NV_OP_W-1:0] OP_READ  = NV_OP_W'(4'h5);
  localparam logic [NV_OP_W-1:0] OP_WRITE = NV_OP_W'(4'hA);

  typedef struct packed {
    logic                 wrBit;
    logic                 rdBit;
    logic                 dIn;
    logic [NV_ADDR_W-1:0] addr;
    logic [NV_BIT_W-1:0]  bitSel;
  } nvStrobe_t;
endpackage

// File: rtl/nvSerialCtrl.sv
module nvSerialCtrl
  import nvSerialPkg::*;
(
  input  logic                clk,
  input  logic                rstAny,
  input  logic                selIn,
  input  logic                sclkIn,
  input  logic                sdiIn,
  output nvStrobe_t           strb,
  output logic [NV_CNT_W-1:0] bitCnt
);
  localparam logic [NV_CNT_W-1:0] CMD_LAST = NV_CNT_W'(NV_CMD_W - 1);
  localparam logic [NV_CNT_W-1:0] FRM_LAST = NV_CNT_W'(NV_LAST_CNT);

  logic                prevClk;
  logic [NV_CMD_W-1:0] cmdReg;
  logic [NV_CMD_W-1:0] cmdNext;
  logic                riseEdge;
  logic                inCmd;
  logic                opKnown;
  logic                takeBit;

  assign riseEdge = sclkIn & ~prevClk;
  assign takeBit  = riseEdge & ~selIn;
  assign inCmd    = (bitCnt < NV_CNT_W'(NV_CMD_W));
  assign cmdNext  = {cmdReg[NV_CMD_W-2:0], sdiIn};
  assign opKnown  = (cmdNext[NV_CMD_W-1 -: NV_OP_W] == OP_READ) ||
                    (cmdNext[NV_CMD_W-1 -: NV_OP_W] == OP_WRITE);

  always_ff @(posedge clk) begin
    if (rstAny) begin
      prevClk <= 1'b1;
      cmdReg  <= '0;
      bitCnt  <= '0;
    end else begin
      prevClk <= sclkIn;
      if (selIn) begin
        bitCnt <= '0;
      end else if (riseEdge) begin
        if (inCmd) begin
          cmdReg <= cmdNext;
          if (bitCnt == CMD_LAST && !opKnown) bitCnt <= '0;
          else                                bitCnt <= bitCnt + 1'b1;
        end else begin
          if (bitCnt == FRM_LAST) bitCnt <= '0;
          else                    bitCnt <= bitCnt + 1'b1;
        end
      end
    end
  end

  always_comb begin
    strb.wrBit  = takeBit & ~inCmd & (cmdReg[NV_CMD_W-1 -: NV_OP_W] == OP_WRITE);
    strb.rdBit  = takeBit & ~inCmd & (cmdReg[NV_CMD_W-1 -: NV_OP_W] == OP_READ);
    strb.dIn    = sdiIn;
    strb.addr   = cmdReg[NV_ADDR_W-1:0];
    strb.bitSel = NV_BIT_W'(FRM_LAST - bitCnt);
  end
endmodule

// File: rtl/nvSerialData.sv
module nvSerialData
  import nvSerialPkg::*;
(
  input  logic      clk,
  input  logic      rstAny,
  input  logic      powerClr,
  input  nvStrobe_t strb,
  output logic      sdoOut
);
  logic [NV_DATA_W-1:0] memArr [NV_DEPTH];

  always_ff @(posedge clk) begin
    if (powerClr) begin
      for (int i = 0; i < NV_DEPTH; i++) memArr[i] <= '0;
    end else if (!rstAny && strb.wrBit) begin
      memArr[strb.addr][strb.bitSel] <= strb.dIn;
    end
  end

  always_ff @(posedge clk) begin
    if (rstAny)          sdoOut <= 1'b1;
    else if (strb.rdBit) sdoOut <= memArr[strb.addr][strb.bitSel];
  end
endmodule

// File: rtl/nvSerialMem.sv
module nvSerialMem
  import nvSerialPkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic powerClr,
  input  logic selIn,
  input  logic sclkIn,
  input  logic sdiIn,
  output logic sdoOut
);
  logic                rstAny;
  nvStrobe_t           strb;
  logic [NV_CNT_W-1:0] bitCnt;

  assign rstAny = rst | powerClr;

  nvSerialCtrl u_ctrl (
    .clk    (clk),
    .rstAny (rstAny),
    .selIn  (selIn),
    .sclkIn (sclkIn),
    .sdiIn  (sdiIn),
    .strb   (strb),
    .bitCnt (bitCnt)
  );

  nvSerialData u_data (
    .clk      (clk),
    .rstAny   (rstAny),
    .powerClr (powerClr),
    .strb     (strb),
    .sdoOut   (sdoOut)
  );
endmodule

// File: rtl/nvSerialMemChk.sv
module nvSerialMemChk
  import nvSerialPkg::*;
(
  input logic                clk,
  input logic                rst,
  input logic                powerClr,
  input logic                selIn,
  input logic                sclkIn,
  input logic                sdoOut,
  input nvStrobe_t           strb,
  input logic [NV_CNT_W-1:0] bitCnt
);
  p_reset_out_r1: assert property (@(posedge clk) rst |=> sdoOut);

  p_clr_out_r2: assert property (@(posedge clk) powerClr |=> sdoOut);

  p_sel_idle_r3: assert property (@(posedge clk) disable iff (rst || powerClr)
    selIn |=> (bitCnt == '0));

  p_sel_no_strobe_r3: assert property (@(posedge clk) disable iff (rst || powerClr)
    selIn |-> !(strb.wrBit || strb.rdBit));

  p_rise_only_r4: assert property (@(posedge clk) disable iff (rst || powerClr)
    (strb.wrBit || strb.rdBit) |-> (sclkIn && !$past(sclkIn)));

  p_data_phase_r6: assert property (@(posedge clk) disable iff (rst || powerClr)
    (strb.wrBit || strb.rdBit) |-> (bitCnt >= NV_CNT_W'(NV_CMD_W)));

  p_rw_excl_r7: assert property (@(posedge clk) disable iff (rst || powerClr)
    $onehot0({strb.wrBit, strb.rdBit}));

  p_wrap_r9: assert property (@(posedge clk) disable iff (rst || powerClr)
    ((strb.wrBit || strb.rdBit) && bitCnt == NV_CNT_W'(NV_LAST_CNT)) |=> (bitCnt == '0));

  p_out_hold_r10: assert property (@(posedge clk) disable iff (rst || powerClr)
    !strb.rdBit |=> $stable(sdoOut));
endmodule

bind nvSerialMem nvSerialMemChk u_chk (
  .clk      (clk),
  .rst      (rst),
  .powerClr (powerClr),
  .selIn    (selIn),
  .sclkIn   (sclkIn),
  .sdoOut   (sdoOut),
  .strb     (strb),
  .bitCnt   (bitCnt)
);

// File: tb/sim_nvSerialMem.sv
`timescale 1ns/1ps
module sim_nvSerialMem;
  logic clk = 1'b0;
  logic rst, powerClr, selIn, sclkIn, sdiIn;
  logic sdoOut;

  always #2.5 clk = ~clk;

  nvSerialMem u0 (
    .clk(clk), .rst(rst), .powerClr(powerClr), .selIn(selIn),
    .sclkIn(sclkIn), .sdiIn(sdiIn), .sdoOut(sdoOut)
  );

  typedef struct { logic b; string tag; } expItem_t;
  expItem_t expQ[$];

  logic [7:0] refMem [16];
  logic       refOut;
  bit         sampleNow = 1'b0;
  int         nChk = 0;
  int         nFail = 0;

  task automatic check(input bit ok, input string tag, input logic act, input logic exp);
    nChk++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s: sdoOut=%0b expected %0b at %0t", tag, act, exp, $time);
    end
  endtask

  // monitor: compares each read bit one step after the taking edge
  initial begin
    expItem_t e;
    forever begin
      @(posedge clk);
      #1;
      if (sampleNow) begin
        if (expQ.size() == 0) begin
          nChk++; nFail++;
          $display("FAIL %s: unexpected sample, got %0b expected none", "R8", sdoOut);
        end else begin
          e = expQ.pop_front();
          check(sdoOut === e.b, e.tag, sdoOut, e.b);
        end
      end
    end
  end

  task automatic sendBit(input logic b, input bit smp, input int hold);
    @(negedge clk); sclkIn = 1'b0; sdiIn = b;
    @(negedge clk); sclkIn = 1'b1; sampleNow = smp;
    @(negedge clk); sampleNow = 1'b0;
    repeat (hold) @(negedge clk);
  endtask

  task automatic sendCmd(input logic [7:0] c, input int hold);
    for (int i = 7; i >= 0; i--) sendBit(c[i], 1'b0, hold);
  endtask

  task automatic writeByte(input logic [3:0] a, input logic [7:0] v, input int hold);
    sendCmd({4'hA, a}, hold);
    for (int i = 7; i >= 0; i--) sendBit(v[i], 1'b0, hold);
    refMem[a] = v;
  endtask

  task automatic readByte(input logic [3:0] a, input int hold, input string tag);
    sendCmd({4'h5, a}, hold);
    for (int i = 7; i >= 0; i--) begin
      expQ.push_back('{refMem[a][i], tag});
      sendBit(1'b0, 1'b1, hold);
    end
    refOut = refMem[a][0];
  endtask

  task automatic chkOut(input string tag);
    @(negedge clk);
    check(sdoOut === refOut, tag, sdoOut, refOut);
  endtask

  task automatic setSel(input logic v);
    @(negedge clk); selIn = v;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nFail++;
    $display("FAIL watchdog (R1..): run hung, got no end expected end");
    $display("  [TB] %0d tests run, %0d failed", nChk, nFail);
    $finish;
  end

  initial begin
    rst = 1'b1; powerClr = 1'b1; selIn = 1'b1; sclkIn = 1'b0; sdiIn = 1'b0;
    for (int i = 0; i < 16; i++) refMem[i] = 8'h00;
    refOut = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0; powerClr = 1'b0;
    chkOut("R1");
    setSel(1'b0);

    readByte(4'd3, 0, "R2");
    writeByte(4'd3, 8'hA5, 0);
    chkOut("R10");
    readByte(4'd3, 0, "R7");
    writeByte(4'd0, 8'h81, 0);
    writeByte(4'd15, 8'h7E, 1);
    readByte(4'd0, 0, "R5");
    readByte(4'd15, 2, "R4");
    readByte(4'd3, 0, "R9");

    // unknown operation codes, then a read right away
    sendCmd(8'h33, 0);
    chkOut("R10");
    sendCmd(8'hF7, 1);
    readByte(4'd15, 0, "R6");

    // select cuts a command halfway
    sendBit(1'b0, 1'b0, 0); sendBit(1'b1, 1'b0, 0);
    sendBit(1'b0, 1'b0, 0); sendBit(1'b1, 1'b0, 0);
    setSel(1'b1); repeat (2) @(negedge clk); setSel(1'b0);
    readByte(4'd0, 0, "R3");

    // select cuts a write after three data bits
    sendCmd(8'hA5, 0);
    sendBit(1'b1, 1'b0, 0); sendBit(1'b1, 1'b0, 0); sendBit(1'b1, 1'b0, 0);
    setSel(1'b1); setSel(1'b0);
    refMem[5] = (refMem[5] & 8'h1F) | 8'hE0;
    chkOut("R10");
    readByte(4'd5, 0, "R3");

    // plain reset keeps the contents
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    refOut = 1'b1;
    chkOut("R1");
    readByte(4'd3, 0, "R1");

    // power-on clear zeroes the contents
    @(negedge clk); powerClr = 1'b1;
    @(negedge clk); powerClr = 1'b0;
    for (int i = 0; i < 16; i++) refMem[i] = 8'h00;
    refOut = 1'b1;
    chkOut("R2");
    readByte(4'd15, 0, "R2");

    repeat (5) @(negedge clk);
    if (expQ.size() != 0) begin
      nChk++; nFail++;
      $display("FAIL R8: %0d pending reads, expected 0", expQ.size());
    end
    $display("  [TB] %0d tests run, %0d failed", nChk, nFail);
    $finish;
  end
endmodule